// File: doc/BRIEF.md
# Bank-Switched Two-Port Memory Router

This block is a shared word memory with two independent ports, called left and right. The storage is split into equal banks. Each bank has one input that hands it to one port, and that port alone may read and write it. Bank ownership comes from these static inputs and not from arbitration, so both ports can work at the same time as long as they touch different banks. Each bank has exactly one owner in any cycle, so the block needs no collision logic.

Each port has a bank field, a word address within the bank, an enable, a mailbox-select qualifier, a write strobe, an output enable, two byte-lane enables and a 16-bit data bus in each direction. A port reaches memory only when its enable is high and its mailbox select is low. A write to a bank the port does not own is dropped without a trace. A read from such a bank returns all zeros and raises that port's not-owner flag. Reads are registered: each port's result appears one clock after the request.

Inside each port a small state machine decides what the port shows in the cycle after a request. It has three states. PS_IDLE drives zeros. PS_DATA shows the captured word. PS_DENY shows zeros with the flag raised. The request seen in each cycle picks the next state:
- no access or a write leads to PS_IDLE;
- a read of an owned bank leads to PS_DATA;
- a read of a foreign bank leads to PS_DENY.

Any state can move to any other state.

Top module: `bsw_router`

## Requirements
- R1: After reset, and until the first read, both ports drive read data 0 and a low not-owner flag.
- R2: The bank field picks the bank, with bank b being value b. The word address picks the word inside that bank. The same word address in different banks holds independent data.
- R3: A bank whose select bit `bank_to_left[b]` is 1 belongs to the left port. When the bit is 0 the bank belongs to the right port. Any mix from zero to all banks per port is allowed.
- R4: The two ports may write and read different banks in the same cycle without affecting each other.
- R5: A write from a port to a bank it does not own leaves that bank's contents unchanged.
- R6: A read from a port to a bank it does not own gives read data 0 and not-owner flag 1 on the next cycle. The flag is 0 in every other case.
- R7: On a write, the upper enable updates bits 15:8 and the lower enable updates bits 7:0. Disabled lanes keep their old value.
- R8: Read data appears exactly one clock after an owned read. It is 0 if output enable was low, and each disabled byte lane reads as 0. In every cycle that does not follow a read, read data is 0.
- R9: With enable low or mailbox select high, a port neither writes nor reads, whatever its other inputs.
- R10: Changing the owner of one bank leaves the contents of every bank intact. It also leaves traffic in the other banks undisturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_to_left | input | NUM_BANKS | Per-bank owner select: 1 = left, 0 = right |
| l_en | input | 1 | Left port enable |
| l_mbx | input | 1 | Left mailbox select; memory access needs it low |
| l_we | input | 1 | Left write strobe (1 write, 0 read) |
| l_oe | input | 1 | Left output enable for reads |
| l_ube | input | 1 | Left upper byte enable (bits 15:8) |
| l_lbe | input | 1 | Left lower byte enable (bits 7:0) |
| l_bank | input | BSEL_W | Left bank field |
| l_addr | input | WORD_AW | Left word address within the bank |
| l_wdata | input | 16 | Left write data |
| l_rdata | output | 16 | Left read data, one clock after the request |
| l_deny | output | 1 | Left not-owner flag for the previous read |
| r_en | input | 1 | Right port enable |
| r_mbx | input | 1 | Right mailbox select; memory access needs it low |
| r_we | input | 1 | Right write strobe (1 write, 0 read) |
| r_oe | input | 1 | Right output enable for reads |
| r_ube | input | 1 | Right upper byte enable (bits 15:8) |
| r_lbe | input | 1 | Right lower byte enable (bits 7:0) |
| r_bank | input | BSEL_W | Right bank field |
| r_addr | input | WORD_AW | Right word address within the bank |
| r_wdata | input | 16 | Right write data |
| r_rdata | output | 16 | Right read data, one clock after the request |
| r_deny | output | 1 | Right not-owner flag for the previous read |

## Verification
The properties assume that the select bit of a bank stays stable from the request edge to the next edge whenever either port accesses that bank. They also assume that the bank field is always below the bank count. The stimulus changes ownership only at the same falling edge at which it applies new requests. It keeps every bank field within range. It reads back only words that it has written before, so that no undefined storage reaches a comparison.

// File: rtl/bsw_pkg.sv
package bsw_pkg;
    localparam int DATA_W = 16;
    localparam int LANES  = 2;
    localparam int LANE_W = DATA_W / LANES;

    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_DATA = 2'd1,
        PS_DENY = 2'd2
    } port_state_e;

    typedef enum logic [1:0] {
        RQ_NONE    = 2'd0,
        RQ_WRITE   = 2'd1,
        RQ_RD_OWN  = 2'd2,
        RQ_RD_FGN  = 2'd3
    } req_kind_e;
endpackage

// File: rtl/bsw_bank.sv
module bsw_bank
    import bsw_pkg::*;
#(
    parameter int WORD_AW = 4
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [LANES-1:0]     wr_lanes,
    input  logic [WORD_AW-1:0]   wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [WORD_AW-1:0]   rd_addr,
    output logic [DATA_W-1:0]    rd_word
);
    localparam int DEPTH = 1 << WORD_AW;

    logic [DATA_W-1:0] store [DEPTH];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (wr_en && wr_lanes[g]) begin
                store[wr_addr][g*LANE_W +: LANE_W] <= wr_data[g*LANE_W +: LANE_W];
            end
        end
    end

    assign rd_word = store[rd_addr];
endmodule

// File: rtl/bsw_port.sv
module bsw_port
    import bsw_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int WORD_AW   = 4,
    parameter bit IS_LEFT   = 1'b1,
    localparam int BSEL_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_BANKS-1:0]            bank_to_left,
    input  logic                            en,
    input  logic                            mbx,
    input  logic                            we,
    input  logic                            oe,
    input  logic                            ube,
    input  logic                            lbe,
    input  logic [BSEL_W-1:0]               bank,
    input  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_words,
    output logic                            wr_go,
    output logic [LANES-1:0]                wr_lanes,
    output logic [DATA_W-1:0]               rdata,
    output logic                            deny
);
    logic [NUM_BANKS-1:0] own_vec;
    logic                 owned;
    logic                 access;
    logic [LANES-1:0]     lane_en;
    logic [DATA_W-1:0]    gated_word;
    req_kind_e            kind;
    port_state_e          state_q, state_d;
    logic [DATA_W-1:0]    data_q, data_d;

    assign own_vec  = IS_LEFT ? bank_to_left : ~bank_to_left;
    assign owned    = own_vec[bank];
    assign access   = en && !mbx;
    assign lane_en  = {ube, lbe};
    assign wr_go    = (kind == RQ_WRITE);
    assign wr_lanes = lane_en;

    for (genvar g = 0; g < LANES; g++) begin : g_gate
        assign gated_word[g*LANE_W +: LANE_W] =
            (oe && lane_en[g]) ? bank_words[bank][g*LANE_W +: LANE_W] : '0;
    end

    always_comb begin
        if (!access)        kind = RQ_NONE;
        else if (we)        kind = owned ? RQ_WRITE : RQ_NONE;
        else if (owned)     kind = RQ_RD_OWN;
        else                kind = RQ_RD_FGN;
    end

    always_comb begin
        state_d = PS_IDLE;
        data_d  = '0;
        unique case (kind)
            RQ_NONE:   state_d = PS_IDLE;
            RQ_WRITE:  state_d = PS_IDLE;
            RQ_RD_OWN: begin
                state_d = PS_DATA;
                data_d  = gated_word;
            end
            RQ_RD_FGN: state_d = PS_DENY;
            default:   state_d = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            data_q  <= data_d;
        end
    end

    always_comb begin
        rdata = '0;
        deny  = 1'b0;
        unique case (state_q)
            PS_IDLE: ;
            PS_DATA: rdata = data_q;
            PS_DENY: deny  = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/bsw_router.sv
module bsw_router
    import bsw_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int WORD_AW   = 4,
    localparam int BSEL_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] bank_to_left,
    input  logic                 l_en,
    input  logic                 l_mbx,
    input  logic                 l_we,
    input  logic                 l_oe,
    input  logic                 l_ube,
    input  logic                 l_lbe,
    input  logic [BSEL_W-1:0]    l_bank,
    input  logic [WORD_AW-1:0]   l_addr,
    input  logic [15:0]          l_wdata,
    output logic [15:0]          l_rdata,
    output logic                 l_deny,
    input  logic                 r_en,
    input  logic                 r_mbx,
    input  logic                 r_we,
    input  logic                 r_oe,
    input  logic                 r_ube,
    input  logic                 r_lbe,
    input  logic [BSEL_W-1:0]    r_bank,
    input  logic [WORD_AW-1:0]   r_addr,
    input  logic [15:0]          r_wdata,
    output logic [15:0]          r_rdata,
    output logic                 r_deny
);
    logic [NUM_BANKS-1:0][DATA_W-1:0] bank_words;
    logic                             l_wr_go, r_wr_go;
    logic [LANES-1:0]                 l_lanes, r_lanes;

    bsw_port #(.NUM_BANKS(NUM_BANKS), .WORD_AW(WORD_AW), .IS_LEFT(1'b1)) u_lport (
        .clk(clk), .rst_n(rst_n), .bank_to_left(bank_to_left),
        .en(l_en), .mbx(l_mbx), .we(l_we), .oe(l_oe), .ube(l_ube), .lbe(l_lbe),
        .bank(l_bank), .bank_words(bank_words),
        .wr_go(l_wr_go), .wr_lanes(l_lanes), .rdata(l_rdata), .deny(l_deny)
    );

    bsw_port #(.NUM_BANKS(NUM_BANKS), .WORD_AW(WORD_AW), .IS_LEFT(1'b0)) u_rport (
        .clk(clk), .rst_n(rst_n), .bank_to_left(bank_to_left),
        .en(r_en), .mbx(r_mbx), .we(r_we), .oe(r_oe), .ube(r_ube), .lbe(r_lbe),
        .bank(r_bank), .bank_words(bank_words),
        .wr_go(r_wr_go), .wr_lanes(r_lanes), .rdata(r_rdata), .deny(r_deny)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic               left_owns;
        logic               wen;
        logic [LANES-1:0]   lanes;
        logic [WORD_AW-1:0] waddr;
        logic [WORD_AW-1:0] raddr;
        logic [DATA_W-1:0]  wdata;

        assign left_owns = bank_to_left[b];
        assign wen   = left_owns ? (l_wr_go && (l_bank == BSEL_W'(b)))
                                 : (r_wr_go && (r_bank == BSEL_W'(b)));
        assign lanes = left_owns ? l_lanes : r_lanes;
        assign waddr = left_owns ? l_addr  : r_addr;
        assign raddr = left_owns ? l_addr  : r_addr;
        assign wdata = left_owns ? l_wdata : r_wdata;

        bsw_bank #(.WORD_AW(WORD_AW)) u_bank (
            .clk(clk), .wr_en(wen), .wr_lanes(lanes), .wr_addr(waddr),
            .wr_data(wdata), .rd_addr(raddr), .rd_word(bank_words[b])
        );
    end
endmodule

// File: rtl/bsw_router_chk.sv
module bsw_router_chk #(
    parameter int NUM_BANKS = 4,
    parameter int WORD_AW   = 4,
    localparam int BSEL_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_BANKS-1:0] bank_to_left,
    input logic                 l_en, l_mbx, l_we, l_oe, l_ube, l_lbe,
    input logic [BSEL_W-1:0]    l_bank,
    input logic [15:0]          l_rdata,
    input logic                 l_deny,
    input logic                 r_en, r_mbx, r_we, r_oe, r_ube, r_lbe,
    input logic [BSEL_W-1:0]    r_bank,
    input logic [15:0]          r_rdata,
    input logic                 r_deny
);
    logic l_rd, r_rd;
    assign l_rd = l_en && !l_mbx && !l_we;
    assign r_rd = r_en && !r_mbx && !r_we;

    // R6: a raised flag always comes with zero data
    p_deny_filler_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (l_deny |-> l_rdata == 16'h0) and (r_deny |-> r_rdata == 16'h0));

    // R6, R3: foreign read raises the flag on the next cycle
    p_deny_left_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (l_rd && !bank_to_left[l_bank]) |=> l_deny);
    p_deny_right_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_rd && bank_to_left[r_bank]) |=> r_deny);

    // R6, R3: owned reads never raise the flag
    p_own_no_deny_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((l_rd && bank_to_left[l_bank]) |=> !l_deny) and
        ((r_rd && !bank_to_left[r_bank]) |=> !r_deny));

    // R9: no access means quiet outputs next cycle
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((!l_en || l_mbx) |=> (l_rdata == 16'h0 && !l_deny)) and
        ((!r_en || r_mbx) |=> (r_rdata == 16'h0 && !r_deny)));

    // R8: writes produce no read response
    p_write_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((l_en && !l_mbx && l_we) |=> (l_rdata == 16'h0 && !l_deny)) and
        ((r_en && !r_mbx && r_we) |=> (r_rdata == 16'h0 && !r_deny)));

    // R8: output enable and byte lanes gate the read data
    p_oe_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((l_rd && !l_oe) |=> l_rdata == 16'h0) and
        ((r_rd && !r_oe) |=> r_rdata == 16'h0));
    p_lane_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((l_rd && !l_ube) |=> l_rdata[15:8] == 8'h0) and
        ((l_rd && !l_lbe) |=> l_rdata[7:0] == 8'h0) and
        ((r_rd && !r_ube) |=> r_rdata[15:8] == 8'h0) and
        ((r_rd && !r_lbe) |=> r_rdata[7:0] == 8'h0));
endmodule

bind bsw_router bsw_router_chk #(.NUM_BANKS(NUM_BANKS), .WORD_AW(WORD_AW)) u_chk (.*);

// File: tb/sim_bsw_router.sv
module sim_bsw_router;
    localparam int NB    = 4;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic en, mbx, we, oe, ube, lbe;
        logic [1:0] bank;
        logic [AW-1:0] addr;
        logic [15:0] wdata;
    } req_t;

    typedef struct {
        int          due;
        logic [15:0] d;
        logic        dn;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NB-1:0] own = '0, own_nxt = '0;
    req_t lq = '0, rq = '0;
    logic [15:0] l_rdata, r_rdata;
    logic l_deny, r_deny;

    int checks = 0, errors = 0, cyc = 0;
    exp_t qL[$], qR[$];
    logic [15:0] mdl [NB][DEPTH];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bsw_router #(.NUM_BANKS(NB), .WORD_AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .bank_to_left(own),
        .l_en(lq.en), .l_mbx(lq.mbx), .l_we(lq.we), .l_oe(lq.oe), .l_ube(lq.ube), .l_lbe(lq.lbe),
        .l_bank(lq.bank), .l_addr(lq.addr), .l_wdata(lq.wdata), .l_rdata(l_rdata), .l_deny(l_deny),
        .r_en(rq.en), .r_mbx(rq.mbx), .r_we(rq.we), .r_oe(rq.oe), .r_ube(rq.ube), .r_lbe(rq.lbe),
        .r_bank(rq.bank), .r_addr(rq.addr), .r_wdata(rq.wdata), .r_rdata(r_rdata), .r_deny(r_deny)
    );

    function automatic req_t mk(logic we, logic [1:0] b, logic [AW-1:0] a, logic [15:0] wd,
                                logic oe = 1'b1, logic ube = 1'b1, logic lbe = 1'b1,
                                logic en = 1'b1, logic mbx = 1'b0);
        req_t t;
        t.en = en; t.mbx = mbx; t.we = we; t.oe = oe; t.ube = ube; t.lbe = lbe;
        t.bank = b; t.addr = a; t.wdata = wd;
        return t;
    endfunction

    function automatic req_t idle();
        return '0;
    endfunction

    function automatic exp_t expect_of(req_t t, bit left, string tag);
        exp_t e;
        logic ow;
        logic [15:0] w;
        ow = left ? own[t.bank] : !own[t.bank];
        e.due = cyc + 1; e.tag = tag; e.d = 16'h0; e.dn = 1'b0;
        if (t.en && !t.mbx && !t.we) begin
            if (!ow) e.dn = 1'b1;
            else if (t.oe) begin
                w = mdl[t.bank][t.addr];
                e.d = {t.ube ? w[15:8] : 8'h0, t.lbe ? w[7:0] : 8'h0};
            end
        end
        return e;
    endfunction

    task automatic model_write(req_t t, bit left);
        logic ow;
        ow = left ? own[t.bank] : !own[t.bank];
        if (t.en && !t.mbx && t.we && ow) begin
            if (t.ube) mdl[t.bank][t.addr][15:8] = t.wdata[15:8];
            if (t.lbe) mdl[t.bank][t.addr][7:0]  = t.wdata[7:0];
        end
    endtask

    // driver: applies one request per port and pushes the expected responses
    task automatic drive(req_t l, string lt, req_t r, string rt);
        @(negedge clk);
        own = own_nxt;
        lq = l; rq = r;
        qL.push_back(expect_of(l, 1'b1, lt));
        qR.push_back(expect_of(r, 1'b0, rt));
        model_write(l, 1'b1);
        model_write(r, 1'b0);
    endtask

    task automatic cmp(string side, exp_t e, logic [15:0] d, logic dn);
        checks++;
        if (d !== e.d || dn !== e.dn) begin
            errors++;
            $display("FAIL %s %s port: got data=%h deny=%b expected data=%h deny=%b",
                     e.tag, side, d, dn, e.d, e.dn);
        end
    endtask

    // monitor: pops scoreboard items whose response cycle has arrived
    always @(negedge clk) begin
        while (qL.size() > 0 && qL[0].due == cyc) cmp("left", qL.pop_front(), l_rdata, l_deny);
        while (qR.size() > 0 && qR[0].due == cyc) cmp("right", qR.pop_front(), r_rdata, r_deny);
    end

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h1d5a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        checks++;
        if (l_rdata !== 16'h0 || l_deny !== 1'b0 || r_rdata !== 16'h0 || r_deny !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: got l=%h/%b r=%h/%b expected 0000/0", l_rdata, l_deny, r_rdata, r_deny);
        end

        // R3/R4: banks 0,1 left; 2,3 right; concurrent writes then reads
        own_nxt = 4'b0011;
        drive(mk(1, 0, 3, 16'h1234), "R4", mk(1, 2, 3, 16'hABCD), "R4");
        drive(mk(1, 1, 3, 16'h5555), "R2", mk(1, 3, 3, 16'h6666), "R2");
        drive(mk(0, 0, 3, 0), "R4", mk(0, 2, 3, 0), "R4");
        drive(mk(0, 1, 3, 0), "R2", mk(0, 3, 3, 0), "R2");
        // R2 boundary words
        drive(mk(1, 0, 0, 16'h0F0F), "R2", mk(1, 2, DEPTH-1, 16'hF00F), "R2");
        drive(mk(0, 0, 0, 0), "R2", mk(0, 2, DEPTH-1, 0), "R2");

        // R5/R6: foreign write dropped, foreign read denied
        drive(mk(1, 2, 3, 16'hDEAD), "R5", mk(1, 0, 3, 16'hBEEF), "R5");
        drive(mk(0, 2, 3, 0), "R6", mk(0, 0, 3, 0), "R6");
        drive(mk(0, 0, 3, 0), "R5", mk(0, 2, 3, 0), "R5");

        // R7: byte-lane writes
        drive(mk(1, 0, 3, 16'hEE99, 1, 1, 0), "R7", mk(1, 2, 3, 16'h7711, 1, 0, 1), "R7");
        drive(mk(0, 0, 3, 0), "R7", mk(0, 2, 3, 0), "R7");

        // R8: output enable and lane gating on reads
        drive(mk(0, 0, 3, 0, 0), "R8", mk(0, 2, 3, 0, 1, 1, 0), "R8");
        drive(mk(0, 1, 3, 0, 1, 0, 1), "R8", idle(), "R8");

        // R9: disabled or mailbox-qualified accesses do nothing
        drive(mk(1, 0, 3, 16'h0000, 1, 1, 1, 0), "R9", mk(1, 2, 3, 16'h0000, 1, 1, 1, 1, 1), "R9");
        drive(mk(0, 0, 3, 0, 1, 1, 1, 1, 1), "R9", mk(0, 2, 3, 0, 1, 1, 1, 0), "R9");
        drive(mk(0, 0, 3, 0), "R9", mk(0, 2, 3, 0), "R9");

        // R10: hand bank 0 to the right while left keeps using bank 1
        own_nxt = 4'b0010;
        drive(mk(0, 1, 3, 0), "R10", mk(0, 0, 3, 0), "R10");
        drive(mk(1, 1, 5, 16'h3C3C), "R10", mk(1, 0, 5, 16'hC3C3), "R10");
        drive(mk(0, 0, 3, 0), "R3", mk(0, 1, 5, 0), "R3");
        drive(mk(0, 1, 5, 0), "R10", mk(0, 0, 5, 0), "R10");

        // R3: right owns all, then left owns all
        own_nxt = 4'b0000;
        for (int b = 0; b < NB; b++) drive(mk(0, b[1:0], 5, 0), "R3", mk(0, b[1:0], 3, 0), "R3");
        own_nxt = 4'b1111;
        for (int b = 0; b < NB; b++) drive(mk(0, b[1:0], 3, 0), "R3", mk(0, b[1:0], 5, 0), "R3");

        // R4/R2: mixed ownership sweep with pseudo-random data
        own_nxt = 4'b0101;
        for (int i = 0; i < 40; i++) begin
            seed = seed * 1103515245 + 12345;
            drive(mk(1, 2'((i % 2) * 2), AW'(i), seed[31:16]), "R4",
                  mk(1, 2'((i % 2) * 2 + 1), AW'(i), seed[15:0]), "R4");
        end
        for (int i = 0; i < 40; i++)
            drive(mk(0, 2'((i % 2) * 2), AW'(i), 0), "R2", mk(0, 2'((i % 2) * 2 + 1), AW'(i), 0), "R2");

        drive(idle(), "R8", idle(), "R8");
        drive(idle(), "R8", idle(), "R8");
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule